// File: doc/BRIEF.md
# Software-Refilled Multi-Page-Size Translation Buffer

This block translates 32-bit effective addresses into physical addresses. It holds eight fully associative entries, and any translation can sit in any slot. Each entry maps one page, and the page can be 4 KB, 16 KB, 512 KB or 8 MB. An entry is tagged with a 4-bit address-space number and belongs to one of eight protection groups. It also carries per-page write-permission bits and two cache attributes: cache-inhibit and copy-back. When the page is 4 KB, the permission bits are kept separately for each 1 KB quarter.

A lookup request returns its result one cycle later. The result gives hit or miss, the physical address, the attributes and a protection-fault flag. On a miss the block only reports the miss and latches the faulting address. It never fetches a translation itself.

Refill software loads entries through a write port. The slot is either named explicitly or chosen by a round-robin victim pointer. The write port can also invalidate a single entry. A separate flush input clears every entry in one cycle. Three scratch registers give the refill routine working storage.

Top module: `vm_xlate_tlb`

## Requirements
- R1: A lookup presented with `lk_req` in cycle N produces, in cycle N+1, `rs_valid`=1 and exactly one of `rs_hit`/`rs_miss`. When there is no request, `rs_valid`, `rs_hit` and `rs_miss` are 0. Any valid entry in any slot can hit.
- R2: Page-size code 0, 1, 2 and 3 selects 4 KB, 16 KB, 512 KB and 8 MB. These give 12, 14, 19 and 23 offset bits. The tag compare ignores the offset bits of the entry's size. On a hit, `rs_pa` takes its offset bits from the effective address and its upper bits from the entry's physical base.
- R3: An entry matches only when its stored address-space number equals `lk_asid`.
- R4: `grp_rights` holds two bits per protection group, with group g at bits [2g+1:2g]. Code 0 means no access, so every access faults. Code 1 means read only, so writes fault. Code 2 means the page write bits decide. Code 3 means full access, with no fault. `rs_fault` is only ever 1 on a hit.
- R5: With rights code 2, a write faults when its permission bit is 0. For a 4 KB page that bit is `wp[ea[11:10]]`, one per 1 KB quarter. Larger pages use `wp[0]` for the whole page.
- R6: On a hit, `rs_ci` and `rs_cb` equal the entry's stored attributes. On a miss, `rs_pa`, `rs_ci`, `rs_cb` and `rs_fault` are 0.
- R7: A miss sets `rs_miss`, and `miss_ea` takes the missing address in the same cycle. `miss_ea` holds that value through later hits until the next miss.
- R8: A write with `wr_use_idx`=0 goes to the slot named by the victim pointer. The pointer is 0 after reset and advances by one, wrapping from 7 to 0, only on such a write. Writes with `wr_use_idx`=1 go to `wr_idx` and leave the pointer unchanged.
- R9: `wr_en` together with `wr_inv` clears the entry at `wr_idx` and leaves all other entries unchanged.
- R10: `inv_all` clears every entry in one cycle. It takes priority over a write in the same cycle, and that write is discarded.
- R11: When more than one valid entry matches, `rs_multi`=1 and the lowest-numbered matching entry supplies the result.
- R12: The three scratch registers at `scr_sel` 0 to 2 are written by `scr_we` and read back on `scr_rdata`. Select 3 reads 0 and its writes are ignored. All registers are 0 after reset.
- R13: After reset no entry is valid, `rs_valid`=0 and `miss_ea`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address to translate |
| lk_asid | input | 4 | Current address-space number |
| lk_wr | input | 1 | Access is a write |
| grp_rights | input | 16 | Two rights bits per protection group |
| rs_valid | output | 1 | Result present |
| rs_hit | output | 1 | Translation found |
| rs_miss | output | 1 | No translation found |
| rs_multi | output | 1 | More than one entry matched |
| rs_fault | output | 1 | Protection fault on the hit |
| rs_pa | output | 32 | Physical address |
| rs_ci | output | 1 | Cache-inhibit attribute |
| rs_cb | output | 1 | Copy-back attribute (0 = write-through) |
| miss_ea | output | 32 | Address of the last miss |
| inv_all | input | 1 | Invalidate all entries |
| wr_en | input | 1 | Entry write strobe |
| wr_inv | input | 1 | Invalidate the entry at `wr_idx` instead of loading it |
| wr_use_idx | input | 1 | Use `wr_idx` instead of the victim pointer |
| wr_idx | input | 3 | Explicit slot |
| wr_ea | input | 32 | Effective page address to load |
| wr_pa | input | 32 | Physical page base to load |
| wr_size | input | 2 | Page-size code |
| wr_asid | input | 4 | Address-space number to load |
| wr_grp | input | 3 | Protection group to load |
| wr_wp | input | 4 | Write-permission bits |
| wr_ci | input | 1 | Cache-inhibit attribute to load |
| wr_cb | input | 1 | Copy-back attribute to load |
| scr_we | input | 1 | Scratch register write |
| scr_sel | input | 2 | Scratch register select |
| scr_wdata | input | 32 | Scratch write data |
| scr_rdata | output | 32 | Scratch read data |

## Verification
The assertions check every cycle that each result is exactly one of hit or miss and arrives one cycle after its request. They also check that the low page-offset bits pass straight through, and that a fault or a multiple match only appears on a hit. On a miss they check that the outputs are quiet and `miss_ea` is captured. They follow the victim pointer, which must step only on an auto-slot write, and they confirm that the flush empties the array.

Only the bench scenarios can show the following:
- the physical address above the smallest offset, for each page size;
- address-space filtering;
- the full matrix of group rights against quarter permission bits;
- which entry wins a multiple match;
- where round-robin writes land when the pointer wraps;
- the scratch registers.

// File: rtl/vm_xlate_pkg.sv
package vm_xlate_pkg;
  localparam int AW     = 32;
  localparam int ASID_W = 4;
  localparam int GRP_W  = 3;
  localparam int N_GRP  = 1 << GRP_W;
  localparam int QTR_N  = 4;

  localparam logic [1:0] SZ_4K   = 2'd0;
  localparam logic [1:0] SZ_16K  = 2'd1;
  localparam logic [1:0] SZ_512K = 2'd2;
  localparam logic [1:0] SZ_8M   = 2'd3;

  localparam logic [1:0] RT_NONE = 2'd0;
  localparam logic [1:0] RT_RO   = 2'd1;
  localparam logic [1:0] RT_PAGE = 2'd2;
  localparam logic [1:0] RT_FULL = 2'd3;

  typedef struct packed {
    logic              vld;
    logic [AW-1:0]     va;
    logic [AW-1:0]     pa;
    logic [1:0]        sz;
    logic [ASID_W-1:0] asid;
    logic [GRP_W-1:0]  grp;
    logic [QTR_N-1:0]  wp;
    logic              ci;
    logic              cb;
  } tlb_ent_t;

  function automatic int off_bits(input logic [1:0] sz);
    case (sz)
      SZ_4K:   return 12;
      SZ_16K:  return 14;
      SZ_512K: return 19;
      default: return 23;
    endcase
  endfunction

  function automatic logic [AW-1:0] off_mask(input logic [1:0] sz);
    return (AW'(1) << off_bits(sz)) - AW'(1);
  endfunction

  function automatic logic [AW-1:0] xlate(input logic [AW-1:0] base,
                                          input logic [AW-1:0] ea,
                                          input logic [1:0] sz);
    return (base & ~off_mask(sz)) | (ea & off_mask(sz));
  endfunction

  function automatic logic acc_fault(input logic [1:0] rt, input logic is_wr,
                                     input logic [QTR_N-1:0] wp,
                                     input logic [1:0] sz, input logic [1:0] qtr);
    logic wbit;
    wbit = (sz == SZ_4K) ? wp[qtr] : wp[0];
    case (rt)
      RT_NONE: return 1'b1;
      RT_RO:   return is_wr;
      RT_PAGE: return is_wr & ~wbit;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/vm_xlate_match.sv
module vm_xlate_match
  import vm_xlate_pkg::*;
(
  input  tlb_ent_t          ent,
  input  logic [AW-1:0]     ea,
  input  logic [ASID_W-1:0] asid,
  output logic              hit
);
  logic tag_eq;
  assign tag_eq = (((ea ^ ent.va) & ~off_mask(ent.sz)) == '0);
  assign hit    = ent.vld && (ent.asid == asid) && tag_eq;
endmodule

// File: rtl/vm_xlate_pick.sv
module vm_xlate_pick #(
  parameter  int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic          multi,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hits[i]) idx = IW'(i);
  end
  assign any   = |hits;
  assign multi = |(hits & (hits - N'(1)));
endmodule

// File: rtl/vm_xlate_scratch.sv
module vm_xlate_scratch #(
  parameter  int NUM = 3,
  parameter  int W   = 32,
  localparam int SW  = $clog2(NUM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] sel,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] regs [NUM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) regs[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NUM; i++)
        if (sel == SW'(i)) regs[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM; i++)
      if (sel == SW'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/vm_xlate_tlb.sv
module vm_xlate_tlb
  import vm_xlate_pkg::*;
#(
  parameter  int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lk_req,
  input  logic [AW-1:0]        lk_ea,
  input  logic [ASID_W-1:0]    lk_asid,
  input  logic                 lk_wr,
  input  logic [2*N_GRP-1:0]   grp_rights,
  output logic                 rs_valid,
  output logic                 rs_hit,
  output logic                 rs_miss,
  output logic                 rs_multi,
  output logic                 rs_fault,
  output logic [AW-1:0]        rs_pa,
  output logic                 rs_ci,
  output logic                 rs_cb,
  output logic [AW-1:0]        miss_ea,
  input  logic                 inv_all,
  input  logic                 wr_en,
  input  logic                 wr_inv,
  input  logic                 wr_use_idx,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [AW-1:0]        wr_ea,
  input  logic [AW-1:0]        wr_pa,
  input  logic [1:0]           wr_size,
  input  logic [ASID_W-1:0]    wr_asid,
  input  logic [GRP_W-1:0]     wr_grp,
  input  logic [QTR_N-1:0]     wr_wp,
  input  logic                 wr_ci,
  input  logic                 wr_cb,
  input  logic                 scr_we,
  input  logic [1:0]           scr_sel,
  input  logic [AW-1:0]        scr_wdata,
  output logic [AW-1:0]        scr_rdata
);
  tlb_ent_t           ents [N_ENT];
  logic [N_ENT-1:0]   hit_vec;
  logic [N_ENT-1:0]   valid_vec;
  logic [IDX_W-1:0]   rr_ptr;
  logic [IDX_W-1:0]   wr_slot;
  logic               rr_step;
  logic               any_hit, multi_hit;
  logic [IDX_W-1:0]   win_idx;
  tlb_ent_t           win;
  logic [AW-1:0]      pa_c;
  logic               fault_c;

  // named events for the checker
  assign rr_step = wr_en && !wr_inv && !wr_use_idx && !inv_all;
  assign wr_slot = (wr_inv || wr_use_idx) ? wr_idx : rr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) ents[i] <= '0;
    end else if (inv_all) begin
      for (int i = 0; i < N_ENT; i++) ents[i].vld <= 1'b0;
    end else if (wr_en) begin
      if (wr_inv) ents[wr_slot].vld <= 1'b0;
      else ents[wr_slot] <= '{vld: 1'b1, va: wr_ea, pa: wr_pa, sz: wr_size,
                              asid: wr_asid, grp: wr_grp, wp: wr_wp,
                              ci: wr_ci, cb: wr_cb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_ptr <= '0;
    else if (rr_step) rr_ptr <= (rr_ptr == IDX_W'(N_ENT - 1)) ? '0 : rr_ptr + 1'b1;
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign valid_vec[g] = ents[g].vld;
    vm_xlate_match u_match (
      .ent  (ents[g]),
      .ea   (lk_ea),
      .asid (lk_asid),
      .hit  (hit_vec[g])
    );
  end

  vm_xlate_pick #(.N(N_ENT)) u_pick (
    .hits  (hit_vec),
    .any   (any_hit),
    .multi (multi_hit),
    .idx   (win_idx)
  );

  assign win     = ents[win_idx];
  assign pa_c    = xlate(win.pa, lk_ea, win.sz);
  assign fault_c = acc_fault(grp_rights[2*win.grp +: 2], lk_wr, win.wp, win.sz, lk_ea[11:10]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0; rs_hit <= 1'b0; rs_miss <= 1'b0; rs_multi <= 1'b0;
      rs_fault <= 1'b0; rs_pa <= '0; rs_ci <= 1'b0; rs_cb <= 1'b0;
      miss_ea  <= '0;
    end else begin
      rs_valid <= lk_req;
      rs_hit   <= lk_req && any_hit;
      rs_miss  <= lk_req && !any_hit;
      rs_multi <= lk_req && any_hit && multi_hit;
      rs_fault <= lk_req && any_hit && fault_c;
      rs_pa    <= (lk_req && any_hit) ? pa_c : '0;
      rs_ci    <= lk_req && any_hit && win.ci;
      rs_cb    <= lk_req && any_hit && win.cb;
      if (lk_req && !any_hit) miss_ea <= lk_ea;
    end
  end

  vm_xlate_scratch #(.NUM(3), .W(AW)) u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (scr_we),
    .sel   (scr_sel),
    .wdata (scr_wdata),
    .rdata (scr_rdata)
  );
endmodule

// File: rtl/vm_xlate_chk.sv
module vm_xlate_chk #(
  parameter  int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic [31:0]      lk_ea,
  input logic             rs_valid,
  input logic             rs_hit,
  input logic             rs_miss,
  input logic             rs_multi,
  input logic             rs_fault,
  input logic [31:0]      rs_pa,
  input logic             rs_ci,
  input logic             rs_cb,
  input logic [31:0]      miss_ea,
  input logic             inv_all,
  input logic             rr_step,
  input logic [N_ENT-1:0] valid_vec,
  input logic [IDX_W-1:0] rr_ptr
);
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rs_valid);
  assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $onehot({rs_hit, rs_miss}));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> !rs_hit && !rs_miss);
  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rs_hit |-> rs_pa[11:0] == $past(lk_ea[11:0]));
  assert_fault_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rs_fault |-> rs_hit);
  assert_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rs_miss |-> rs_pa == '0 && !rs_ci && !rs_cb && !rs_fault);
  assert_miss_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rs_miss |-> miss_ea == $past(lk_ea));
  assert_rr_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rr_step |=> rr_ptr == (($past(rr_ptr) == IDX_W'(N_ENT - 1)) ? '0 : $past(rr_ptr) + 1'b1));
  assert_rr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rr_step |=> $stable(rr_ptr));
  assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> valid_vec == '0);
  assert_multi_on_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rs_multi |-> rs_hit);
endmodule

bind vm_xlate_tlb vm_xlate_chk #(.N_ENT(N_ENT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_req    (lk_req),
  .lk_ea     (lk_ea),
  .rs_valid  (rs_valid),
  .rs_hit    (rs_hit),
  .rs_miss   (rs_miss),
  .rs_multi  (rs_multi),
  .rs_fault  (rs_fault),
  .rs_pa     (rs_pa),
  .rs_ci     (rs_ci),
  .rs_cb     (rs_cb),
  .miss_ea   (miss_ea),
  .inv_all   (inv_all),
  .rr_step   (rr_step),
  .valid_vec (valid_vec),
  .rr_ptr    (rr_ptr)
);

// File: tb/test_vm_xlate_tlb.sv
`timescale 1ns/1ps
module test_vm_xlate_tlb;
  logic clk = 0, rst_n = 0;
  logic lk_req = 0, lk_wr = 0;
  logic [31:0] lk_ea = 0;
  logic [3:0]  lk_asid = 0;
  logic [15:0] grp_rights = 16'hFFFF;
  logic rs_valid, rs_hit, rs_miss, rs_multi, rs_fault, rs_ci, rs_cb;
  logic [31:0] rs_pa, miss_ea, scr_rdata;
  logic inv_all = 0, wr_en = 0, wr_inv = 0, wr_use_idx = 0, wr_ci = 0, wr_cb = 0, scr_we = 0;
  logic [2:0]  wr_idx = 0, wr_grp = 0;
  logic [31:0] wr_ea = 0, wr_pa = 0, scr_wdata = 0;
  logic [1:0]  wr_size = 0, scr_sel = 0;
  logic [3:0]  wr_asid = 0, wr_wp = 0;

  int checks = 0, errors = 0;

  // reference model state
  bit          m_vld [8];
  logic [31:0] m_va [8], m_pa [8];
  logic [1:0]  m_sz [8];
  logic [3:0]  m_asid [8], m_wp [8];
  logic [2:0]  m_grp [8];
  bit          m_ci [8], m_cb [8];
  int          m_rr = 0;
  logic [31:0] m_miss = 0;

  always #2 clk = ~clk;

  vm_xlate_tlb i_vm_xlate_tlb (.*);

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  function automatic int offs_of(input logic [1:0] s);
    return (s == 2'd3) ? 23 : (s == 2'd2) ? 19 : 12 + 2 * int'(s);
  endfunction

  task automatic put(input bit use_idx, input int idx, input logic [31:0] va, input logic [31:0] pa,
                     input logic [1:0] sz, input logic [3:0] asid, input logic [2:0] grp,
                     input logic [3:0] wp, input bit ci, input bit cb, input bit flush);
    int slot;
    @(negedge clk);
    wr_en = 1; wr_use_idx = use_idx; wr_idx = 3'(idx); wr_ea = va; wr_pa = pa; wr_size = sz;
    wr_asid = asid; wr_grp = grp; wr_wp = wp; wr_ci = ci; wr_cb = cb; inv_all = flush;
    @(negedge clk);
    wr_en = 0; inv_all = 0; wr_use_idx = 0;
    if (flush) begin
      for (int i = 0; i < 8; i++) m_vld[i] = 0;
    end else begin
      slot = use_idx ? idx : m_rr;
      m_vld[slot] = 1; m_va[slot] = va; m_pa[slot] = pa; m_sz[slot] = sz; m_asid[slot] = asid;
      m_grp[slot] = grp; m_wp[slot] = wp; m_ci[slot] = ci; m_cb[slot] = cb;
      if (!use_idx) m_rr = (m_rr + 1) % 8;
    end
  endtask

  task automatic kill(input int idx);
    @(negedge clk);
    wr_en = 1; wr_inv = 1; wr_idx = 3'(idx);
    @(negedge clk);
    wr_en = 0; wr_inv = 0;
    m_vld[idx] = 0;
  endtask

  task automatic look(input logic [31:0] ea, input logic [3:0] asid, input bit wr, input string rq);
    int win = -1, cnt = 0, o = 12, rt;
    logic [31:0] lowm, e_pa = 0;
    bit e_fault = 0, e_ci = 0, e_cb = 0, wbit;
    for (int i = 0; i < 8; i++) begin
      o = offs_of(m_sz[i]);
      if (m_vld[i] && m_asid[i] == asid && (ea >> o) == (m_va[i] >> o)) begin
        cnt++;
        if (win < 0) win = i;
      end
    end
    if (win >= 0) begin
      o = offs_of(m_sz[win]);
      lowm = (32'h1 << o) - 32'h1;
      e_pa = (m_pa[win] & ~lowm) | (ea & lowm);
      rt = int'((grp_rights >> (2 * int'(m_grp[win]))) & 16'h3);
      wbit = (m_sz[win] == 2'd0) ? m_wp[win][ea[11:10]] : m_wp[win][0];
      e_fault = (rt == 0) || (rt == 1 && wr) || (rt == 2 && wr && !wbit);
      e_ci = m_ci[win]; e_cb = m_cb[win];
    end else m_miss = ea;
    @(negedge clk);
    lk_req = 1; lk_ea = ea; lk_asid = asid; lk_wr = wr;
    @(negedge clk);
    lk_req = 0;
    check(rs_valid == 1, "R1", "valid", 32'(rs_valid), 1);
    check(rs_hit == (win >= 0) && rs_miss == (win < 0), rq, "hit", 32'(rs_hit), 32'(win >= 0));
    check(rs_pa == e_pa, rq, "pa", rs_pa, e_pa);
    check(rs_fault == e_fault, rq, "fault", 32'(rs_fault), 32'(e_fault));
    check(rs_ci == e_ci && rs_cb == e_cb, "R6", "attr", {30'b0, rs_ci, rs_cb}, {30'b0, e_ci, e_cb});
    check(rs_multi == (cnt > 1), "R11", "multi", 32'(rs_multi), 32'(cnt > 1));
    check(miss_ea == m_miss, "R7", "miss_ea", miss_ea, m_miss);
  endtask

  task automatic scr_chk(input int sel, input logic [31:0] exp);
    @(negedge clk);
    scr_sel = 2'(sel);
    #1 check(scr_rdata == exp, "R12", "scratch", scr_rdata, exp);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] bva [4];
    logic [31:0] bpa [4];
    logic [31:0] lm;
    bva[0] = 32'h1000_3000; bpa[0] = 32'h0004_5000;
    bva[1] = 32'h2001_C000; bpa[1] = 32'h0AB0_4000;
    bva[2] = 32'h3008_0000; bpa[2] = 32'h4010_0000;
    bva[3] = 32'h5080_0000; bpa[3] = 32'h6000_0000;
    for (int i = 0; i < 8; i++) begin
      m_vld[i] = 0; m_sz[i] = 0; m_va[i] = 0; m_pa[i] = 0; m_asid[i] = 0;
      m_grp[i] = 0; m_wp[i] = 0; m_ci[i] = 0; m_cb[i] = 0;
    end
    repeat (3) @(negedge clk);
    check(rs_valid == 0, "R13", "reset valid", 32'(rs_valid), 0);
    check(miss_ea == 0, "R13", "reset miss_ea", miss_ea, 0);
    rst_n = 1;
    for (int s = 0; s < 4; s++) scr_chk(s, 0);               // R12 reset
    look(32'h1234_5678, 0, 0, "R13");                        // empty array misses

    // R2 / R8: one entry per size via round-robin slots 0..3
    for (int s = 0; s < 4; s++)
      put(0, 0, bva[s], bpa[s], 2'(s), 4'(4 + s), 0, 4'hF, s[0], s[1], 0);
    for (int s = 0; s < 4; s++) begin
      lm = (32'h1 << offs_of(2'(s))) - 1;
      look(bva[s], 4'(4 + s), 0, "R2");
      look(bva[s] | lm, 4'(4 + s), 1, "R2");
      look(bva[s] | (lm / 3), 4'(4 + s), 0, "R2");
      look((bva[s] | lm) + 1, 4'(4 + s), 0, "R2");
      look(bva[s] - 1, 4'(4 + s), 0, "R2");
      look(bva[s], 4'(3 - s), 0, "R3");                      // wrong space
    end

    // R4 / R5: rights matrix against 1 KB quarter bits
    put(1, 7, 32'h7000_0000, 32'h0123_4000, 2'd0, 4'd1, 3'd5, 4'b0101, 1, 0, 0);
    put(1, 6, 32'h7100_0000, 32'h0200_0000, 2'd1, 4'd1, 3'd5, 4'b1110, 0, 1, 0);
    for (int r = 0; r < 4; r++) begin
      grp_rights = {8{2'(3 - r)}};
      grp_rights[11:10] = 2'(r);
      for (int q = 0; q < 4; q++)
        for (int w = 0; w < 2; w++)
          look(32'h7000_0005 + 32'(q) * 32'h400, 4'd1, w[0], "R5");
      look(32'h7100_0400, 4'd1, 1, "R4");
      look(32'h7100_0800, 4'd1, 0, "R4");
    end
    grp_rights = 16'hFFFF;

    // R11 / R9: overlapping entries, lowest wins, then single invalidate
    put(1, 6, 32'h8000_0000, 32'h1100_0000, 2'd3, 4'd2, 0, 4'hF, 1, 1, 0);
    put(1, 2, 32'h8040_0000, 32'h2200_0000, 2'd0, 4'd2, 0, 4'hF, 0, 0, 0);
    look(32'h8040_0123, 4'd2, 0, "R11");
    look(32'h8000_0010, 4'd2, 0, "R11");
    kill(2);
    look(32'h8040_0123, 4'd2, 0, "R9");
    look(bva[0], 4'd4, 0, "R9");                             // slot 0 untouched

    // R8: explicit writes did not move the pointer; wrap it
    for (int k = 0; k < 10; k++)
      put(0, 0, 32'h9000_0000 + 32'(k) * 32'h1000, 32'hA000_0000 + 32'(k) * 32'h1000,
          2'd0, 4'd3, 0, 4'hF, 0, 0, 0);
    for (int k = 0; k < 10; k++) look(32'h9000_0040 + 32'(k) * 32'h1000, 4'd3, 0, "R8");

    // R10: flush wins over a simultaneous write
    put(1, 1, 32'hB000_0000, 32'hC000_0000, 2'd0, 4'd9, 0, 4'hF, 0, 0, 1);
    look(32'hB000_0000, 4'd9, 0, "R10");
    look(32'h9000_9040, 4'd3, 0, "R10");
    put(1, 1, 32'hB000_0000, 32'hC000_0000, 2'd0, 4'd9, 0, 4'hF, 0, 0, 0);
    look(32'hB000_0ABC, 4'd9, 0, "R10");

    // R12: scratch registers
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      scr_we = 1; scr_sel = 2'(s); scr_wdata = 32'h5A00_0000 + 32'(s) * 32'h11;
      @(negedge clk);
      scr_we = 0;
    end
    for (int s = 0; s < 3; s++) scr_chk(s, 32'h5A00_0000 + 32'(s) * 32'h11);
    scr_chk(3, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule